// File: doc/BRIEF.md
# Memory-Resident Block Transfer Channel

This block moves a block of 12-bit words between a peripheral and main memory. It keeps no transfer count or address of its own. Both live in two adjacent memory words owned by the device. Software stores the negative block length in the first word. It stores one less than the first target address in the second word. Software then pulses the start input with the direction flag set.

For every word, the channel runs five memory operations:

1. It reads the count word, adds one and writes it back.
2. It reads the address word, adds one and writes it back.
3. It moves one data word between the device and the memory location named by the new address value.

The block ends when the incremented count reaches zero. It then gives a one-clock completion pulse and raises an interrupt request. That request stays up until the next accepted start.

Memory is reached through a request/done port. Each request is a one-clock read or write strobe with an address and write data. The memory answers with a done strobe, and read data is valid in the same clock as that strobe. On the device side there is an input word with a one-clock "word taken" strobe for device-to-memory transfers. There is also an output word with a one-clock valid strobe for memory-to-device transfers.

Top module: `data_break_chan`

## Requirements
- R1: After reset, busy, done_pulse, irq, mem_rd, mem_wr, dev_wtake and dev_rvalid are all low.
- R2: For each word the requests come in this fixed order. First, a read of the count location (parameter, default octal 7750). Second, a write to that location of the value read plus one. Third, a read of the count location plus one. Fourth, a write there of the value read plus one. Fifth, a data access at the address just written.
- R3: Every request is a one-clock strobe, and mem_rd and mem_wr are never high together. No new request is issued until mem_done has been seen for the previous one. mem_rdata is taken in the clock mem_done is high.
- R4: With dir_to_mem = 1, the data access is a write of dev_wdata. dev_wtake pulses for one clock together with that write strobe.
- R5: With dir_to_mem = 0, the data access is a read. The word read appears on dev_rdata, and dev_rvalid is high for one clock in the clock after mem_done.
- R6: The transfer stops after the data access of the word whose incremented count is zero, so an initial count of -n moves n words. done_pulse is then high for exactly one clock. irq rises at the same time and stays high until the next accepted start.
- R7: Count and address arithmetic wrap modulo 4096. An address word of 7777 makes the first data access go to 0000. A count word of 0 moves 4096 words.
- R8: A start pulse received while busy is high has no effect on the running transfer, its direction or its length.
- R9: busy rises on the clock edge that accepts start and falls on the edge that completes the last data access, the same edge that raises done_pulse. While busy is low, no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| dir_to_mem | input | 1 | Direction, latched at start: 1 device to memory, 0 memory to device |
| mem_rd | output | 1 | One-clock memory read request |
| mem_wr | output | 1 | One-clock memory write request |
| mem_addr | output | 12 | Memory address of the request |
| mem_wdata | output | 12 | Write data of the request |
| mem_rdata | input | 12 | Read data, valid with mem_done |
| mem_done | input | 1 | Memory completion strobe |
| dev_wdata | input | 12 | Word supplied by the device |
| dev_wtake | output | 1 | Device word has been taken |
| dev_rdata | output | 12 | Word delivered to the device |
| dev_rvalid | output | 1 | dev_rdata is valid for this clock |
| busy | output | 1 | Transfer in progress |
| done_pulse | output | 1 | One-clock completion pulse |
| irq | output | 1 | Interrupt request, held until next start |

## Verification
The bench aims at the edges of the count and address arithmetic.

- A zero count word must move the full 4096 words. A channel that tests the count before incrementing it would stop at once or run one word short.
- An address word of 7777 must wrap to 0000. An address path that carries into a wider register would put data out of range.
- Runs of one and two words catch an off-by-one in termination. Too early or too late shows up as a wrong final count word or a wrong word total.
- A start pulse sent mid-transfer with the opposite direction catches a channel that restarts or flips direction. It would leave the count nonzero or corrupt the data words.
- Memory latencies of one to three clocks catch a sequencer that goes ahead before mem_done.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WC_RD = 3'd1,
    PH_WC_WR = 3'd2,
    PH_CA_RD = 3'd3,
    PH_CA_WR = 3'd4,
    PH_DATA  = 3'd5
  } phase_t;
endpackage

// File: rtl/dbc_fsm.sv
module dbc_fsm
  import dbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   dir_in,
  input  logic   mem_done,
  input  logic   wc_zero,
  output phase_t ph,
  output phase_t nxt,
  output logic   issue,
  output logic   accept,
  output logic   dir_q,
  output logic   busy,
  output logic   done_pulse,
  output logic   irq
);
  logic req_live;
  logic finish;
  logic take_start;

  assign take_start = (ph == PH_IDLE) && start;
  assign accept     = (ph != PH_IDLE) && mem_done && !req_live;

  always_comb begin
    nxt    = ph;
    issue  = 1'b0;
    finish = 1'b0;
    case (ph)
      PH_IDLE:
        if (start) begin
          nxt   = PH_WC_RD;
          issue = 1'b1;
        end
      PH_WC_RD:
        if (accept) begin
          nxt   = PH_WC_WR;
          issue = 1'b1;
        end
      PH_WC_WR:
        if (accept) begin
          nxt   = PH_CA_RD;
          issue = 1'b1;
        end
      PH_CA_RD:
        if (accept) begin
          nxt   = PH_CA_WR;
          issue = 1'b1;
        end
      PH_CA_WR:
        if (accept) begin
          nxt   = PH_DATA;
          issue = 1'b1;
        end
      PH_DATA:
        if (accept) begin
          if (wc_zero) begin
            nxt    = PH_IDLE;
            finish = 1'b1;
          end else begin
            nxt   = PH_WC_RD;
            issue = 1'b1;
          end
        end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      req_live   <= 1'b0;
      dir_q      <= 1'b0;
      busy       <= 1'b0;
      done_pulse <= 1'b0;
      irq        <= 1'b0;
    end else begin
      ph         <= nxt;
      req_live   <= issue;
      done_pulse <= finish;
      if (take_start) begin
        dir_q <= dir_in;
        busy  <= 1'b1;
        irq   <= 1'b0;
      end
      if (finish) begin
        busy <= 1'b0;
        irq  <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse); // R6
  AST_BUSY_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (!busy && $past(busy))); // R9
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !(start && !busy)) |=> irq); // R6
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dir_q)); // R8
endmodule

// File: rtl/dbc_ptr.sv
module dbc_ptr
  import dbc_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        ph,
  input  logic          accept,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] inc,
  output logic [DW-1:0] wc_q,
  output logic [DW-1:0] ca_q,
  output logic          wc_zero
);
  localparam logic [DW-1:0] ONE = DW'(1);

  assign inc     = mem_rdata + ONE;
  assign wc_zero = (wc_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_q <= '1;
      ca_q <= '0;
    end else if (accept) begin
      if (ph == PH_WC_RD) wc_q <= inc;
      if (ph == PH_CA_RD) ca_q <= inc;
    end
  end
endmodule

// File: rtl/dbc_mport.sv
module dbc_mport
  import dbc_pkg::*;
#(
  parameter int              AW     = 12,
  parameter int              DW     = 12,
  parameter logic [AW-1:0]   WC_LOC = 12'o7750
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        ph,
  input  phase_t        nxt,
  input  logic          issue,
  input  logic          accept,
  input  logic          dir_q,
  input  logic [DW-1:0] inc,
  input  logic [DW-1:0] ca_q,
  input  logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_wtake,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_rvalid
);
  localparam logic [AW-1:0] CA_LOC = WC_LOC + AW'(1);

  logic          want_rd, want_wr;
  logic [AW-1:0] want_addr;
  logic [DW-1:0] want_data;

  always_comb begin
    want_rd   = 1'b0;
    want_wr   = 1'b0;
    want_addr = WC_LOC;
    want_data = '0;
    case (nxt)
      PH_WC_RD: want_rd = 1'b1;
      PH_WC_WR: begin
        want_wr   = 1'b1;
        want_data = inc;
      end
      PH_CA_RD: begin
        want_rd   = 1'b1;
        want_addr = CA_LOC;
      end
      PH_CA_WR: begin
        want_wr   = 1'b1;
        want_addr = CA_LOC;
        want_data = inc;
      end
      PH_DATA: begin
        want_rd   = !dir_q;
        want_wr   = dir_q;
        want_addr = AW'(ca_q);
        want_data = dev_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      dev_wtake  <= 1'b0;
      dev_rdata  <= '0;
      dev_rvalid <= 1'b0;
    end else begin
      mem_rd     <= issue && want_rd;
      mem_wr     <= issue && want_wr;
      dev_wtake  <= issue && (nxt == PH_DATA) && dir_q;
      dev_rvalid <= accept && (ph == PH_DATA) && !dir_q;
      if (issue) begin
        mem_addr  <= want_addr;
        mem_wdata <= want_data;
      end
      if (accept && (ph == PH_DATA) && !dir_q)
        dev_rdata <= mem_rdata;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr)); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    dev_rvalid |=> !dev_rvalid); // R5
  AST_TAKE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    dev_wtake |-> mem_wr); // R4
endmodule

// File: rtl/data_break_chan.sv
module data_break_chan
  import dbc_pkg::*;
#(
  parameter int            AW     = 12,
  parameter int            DW     = 12,
  parameter logic [AW-1:0] WC_LOC = 12'o7750
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_to_mem,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_wtake,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_rvalid,
  output logic          busy,
  output logic          done_pulse,
  output logic          irq
);
  phase_t        ph, nxt;
  logic          issue, accept, dir_q, wc_zero;
  logic [DW-1:0] inc, wc_q, ca_q;

  dbc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dir_in     (dir_to_mem),
    .mem_done   (mem_done),
    .wc_zero    (wc_zero),
    .ph         (ph),
    .nxt        (nxt),
    .issue      (issue),
    .accept     (accept),
    .dir_q      (dir_q),
    .busy       (busy),
    .done_pulse (done_pulse),
    .irq        (irq)
  );

  dbc_ptr #(.DW(DW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .accept    (accept),
    .mem_rdata (mem_rdata),
    .inc       (inc),
    .wc_q      (wc_q),
    .ca_q      (ca_q),
    .wc_zero   (wc_zero)
  );

  dbc_mport #(.AW(AW), .DW(DW), .WC_LOC(WC_LOC)) u_mport (
    .clk        (clk),
    .rst        (rst),
    .ph         (ph),
    .nxt        (nxt),
    .issue      (issue),
    .accept     (accept),
    .dir_q      (dir_q),
    .inc        (inc),
    .ca_q       (ca_q),
    .dev_wdata  (dev_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .dev_wtake  (dev_wtake),
    .dev_rdata  (dev_rdata),
    .dev_rvalid (dev_rvalid)
  );

  AST_DATA_AT_CA: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_DATA) && (mem_rd || mem_wr)) |-> (mem_addr == AW'(ca_q))); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mem_wr)); // R9
endmodule

// File: tb/data_break_chan_tb.sv
module data_break_chan_tb;
  localparam logic [11:0] WCL = 12'o7750;
  localparam logic [11:0] CAL = 12'o7751;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, dir_to_mem = 1'b0;
  logic        mem_rd, mem_wr, mem_done, dev_wtake, dev_rvalid, busy, done_pulse, irq;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;

  data_break_chan u_dut (
    .clk(clk), .rst(rst), .start(start), .dir_to_mem(dir_to_mem),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .dev_wdata(dev_wdata),
    .dev_wtake(dev_wtake), .dev_rdata(dev_rdata), .dev_rvalid(dev_rvalid),
    .busy(busy), .done_pulse(done_pulse), .irq(irq)
  );

  // memory model, preload port and logs
  logic [11:0] mem [0:4095];
  logic        pl_we = 1'b0, clr = 1'b0;
  logic [11:0] pl_addr = '0, pl_data = '0;
  int          lat_cfg = 1;
  logic        pend, p_wr;
  logic [11:0] p_addr, p_d;
  int          cnt, req_cnt, overlap, take_cnt, rv_cnt, done_cnt;
  logic [11:0] log_addr [0:7];
  logic        log_wr   [0:7];
  logic [11:0] log_wd   [0:7];
  logic [11:0] rv_log   [0:63];

  assign dev_wdata = 12'(take_cnt * 7 + 12'o1234);

  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; mem_done <= 1'b0; mem_rdata <= '0; cnt <= 0;
      p_wr <= 1'b0; p_addr <= '0; p_d <= '0;
    end else begin
      mem_done <= 1'b0;
      if (mem_rd || mem_wr) begin
        if (pend) overlap <= overlap + 1;
        pend <= 1'b1; p_wr <= mem_wr; p_addr <= mem_addr; p_d <= mem_wdata;
        cnt <= lat_cfg - 1;
      end else if (pend) begin
        if (cnt == 0) begin
          pend <= 1'b0; mem_done <= 1'b1;
          if (p_wr) mem[p_addr] <= p_d; else mem_rdata <= mem[p_addr];
        end else cnt <= cnt - 1;
      end
    end
    if (pl_we) mem[pl_addr] <= pl_data;
    if (clr) begin
      req_cnt <= 0; overlap <= 0; take_cnt <= 0; rv_cnt <= 0; done_cnt <= 0;
    end else begin
      if (mem_rd || mem_wr) begin
        if (req_cnt < 8) begin
          log_addr[req_cnt] <= mem_addr; log_wr[req_cnt] <= mem_wr; log_wd[req_cnt] <= mem_wdata;
        end
        req_cnt <= req_cnt + 1;
      end
      if (dev_wtake) take_cnt <= take_cnt + 1;
      if (dev_rvalid) begin
        if (rv_cnt < 64) rv_log[rv_cnt] <= dev_rdata;
        rv_cnt <= rv_cnt + 1;
      end
      if (done_pulse) done_cnt <= done_cnt + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [11:0] d);
    pl_addr = a; pl_data = d; pl_we = 1'b1;
    @(negedge clk); pl_we = 1'b0;
  endtask

  function automatic logic [11:0] src_pat(input int i);
    return 12'(12'o5000 ^ (i * 11));
  endfunction

  // stimulus table: {dir, latency, count word, address word}
  localparam int NV = 4;
  localparam logic [28:0] VEC [0:NV-1] = '{
    {1'b1, 4'd1, 12'o7775, 12'o0177},
    {1'b0, 4'd3, 12'o7773, 12'o0377},
    {1'b1, 4'd2, 12'o7777, 12'o7777},
    {1'b0, 4'd1, 12'o7776, 12'o7776}
  };

  task automatic launch(input logic dir, input int lat, input logic [11:0] wc, input logic [11:0] ca, input int n, input bit fill);
    poke(WCL, wc); poke(CAL, ca);
    if (fill) for (int i = 0; i < n && i < 64; i++) poke(12'(ca + 12'(i + 1)), src_pat(i));
    lat_cfg = lat;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    dir_to_mem = dir; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    chk(irq == 1'b0, "R6", "irq cleared by start", int'(irq), 0);
  endtask

  task automatic wait_done(input int limit);
    for (int c = 0; c < limit && done_cnt == 0; c++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic verify(input logic dir, input logic [11:0] wc, input logic [11:0] ca, input int n, input bit seq);
    chk(mem[WCL] == 12'o0000, "R6", "final count word", int'(mem[WCL]), 0);
    chk(mem[CAL] == 12'(ca + 12'(n)), "R7", "final address word", int'(mem[CAL]), int'(12'(ca + 12'(n))));
    chk(done_cnt == 1, "R6", "done pulse clocks", done_cnt, 1);
    chk(irq == 1'b1 && busy == 1'b0, "R9", "irq/busy at end", int'({irq, busy}), 2);
    chk(req_cnt == 5 * n, "R3", "request count", req_cnt, 5 * n);
    chk(overlap == 0, "R3", "overlapping requests", overlap, 0);
    if (dir) begin
      chk(take_cnt == n, "R4", "words taken", take_cnt, n);
      for (int i = 0; i < n && i < 64; i++) begin
        logic [11:0] a;
        a = 12'(ca + 12'(i + 1));
        chk(mem[a] == 12'(i * 7 + 12'o1234), "R4", "stored word", int'(mem[a]), int'(12'(i * 7 + 12'o1234)));
      end
    end else begin
      chk(rv_cnt == n, "R5", "words delivered", rv_cnt, n);
      for (int i = 0; i < n && i < 64; i++)
        chk(rv_log[i] == src_pat(i), "R5", "delivered word", int'(rv_log[i]), int'(src_pat(i)));
    end
    if (seq) begin
      chk(log_addr[0] == WCL && !log_wr[0], "R2", "op1 read count", int'(log_addr[0]), int'(WCL));
      chk(log_addr[1] == WCL && log_wr[1] && log_wd[1] == 12'(wc + 1), "R2", "op2 write count", int'(log_wd[1]), int'(12'(wc + 1)));
      chk(log_addr[2] == CAL && !log_wr[2], "R2", "op3 read address", int'(log_addr[2]), int'(CAL));
      chk(log_addr[3] == CAL && log_wr[3] && log_wd[3] == 12'(ca + 1), "R2", "op4 write address", int'(log_wd[3]), int'(12'(ca + 1)));
      chk(log_addr[4] == 12'(ca + 1) && log_wr[4] == dir, "R2", "op5 data access", int'(log_addr[4]), int'(12'(ca + 1)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done_pulse, irq, mem_rd, mem_wr, dev_wtake, dev_rvalid} == 7'b0, "R1", "outputs in reset",
        int'({busy, done_pulse, irq, mem_rd, mem_wr, dev_wtake, dev_rvalid}), 0);
    rst = 1'b0; clr = 1'b0;
    @(negedge clk);
    chk({busy, done_pulse, irq, mem_rd, mem_wr} == 5'b0, "R1", "outputs after reset", int'({busy, irq}), 0);

    for (int v = 0; v < NV; v++) begin
      logic d; int l; logic [11:0] w, a; int n;
      d = VEC[v][28]; l = int'(VEC[v][27:24]); w = VEC[v][23:12]; a = VEC[v][11:0];
      n = int'(12'(-w));
      launch(d, l, w, a, n, !d);
      wait_done(5000);
      verify(d, w, a, n, 1'b1);
    end

    // R8: start with opposite direction while busy
    launch(1'b1, 2, 12'o7774, 12'o1000, 4, 1'b0);
    repeat (12) @(negedge clk);
    dir_to_mem = 1'b0; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(5000);
    chk(done_cnt == 1 && mem[WCL] == 12'o0000, "R8", "restart ignored count", int'(mem[WCL]), 0);
    chk(take_cnt == 4 && rv_cnt == 0, "R8", "restart ignored direction", take_cnt, 4);

    // R7: zero count moves 4096 words
    launch(1'b0, 1, 12'o0000, 12'o2000, 4096, 1'b0);
    wait_done(100000);
    chk(rv_cnt == 4096, "R7", "zero count word total", rv_cnt, 4096);
    chk(mem[WCL] == 12'o0000 && mem[CAL] == 12'o2000, "R7", "zero count final words", int'(mem[CAL]), int'(12'o2000));
    chk(done_cnt == 1 && !busy, "R6", "zero count completion", done_cnt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule